// File: doc/BRIEF.md
# Interrupt Priority Chain Node with Return Snooping

This block is the interrupt logic of one peripheral on an 8-bit microprocessor bus whose devices are wired into a priority chain. An enable level enters from the higher-priority neighbour and an enable level leaves towards the lower-priority neighbour. The node keeps two flags. The pending flag is raised by a one-cycle pulse from the peripheral's interrupt source. The in-service flag is raised when the processor accepts the node's request. Either flag, once set, cuts off everything further down the chain.

The node watches the bus strobes on each rising clock edge. An acknowledge is the processor's machine-cycle-one strobe asserted with the read strobe idle. During an acknowledge, once the I/O request strobe is also asserted, a node that holds the chain enable and has a request pending places its latched 8-bit vector on the data bus. A request is closed without any register write: the node snoops opcode fetches for the two-byte return-from-interrupt sequence and then clears its in-service flag. Only the highest node in service does this, because it is the only one in service whose enable input is high.

Top module: `irq_chain_node`

## Requirements
- R1: While `rst_n` is low, both flags are clear. After reset, `int_n_o` is 1, `data_oe_o` is 0 and `ien_out_o` equals `ien_in_i`.
- R2: An `irq_pulse_i` high at a rising edge sets the pending flag. From then on, `ien_out_o` is 0 for either level of `ien_in_i`.
- R3: `int_n_o` is 0 exactly when the pending flag is set, the in-service flag is clear and `ien_in_i` is 1. Otherwise it is 1.
- R4: Suppose an edge samples `m1_n_i`=0, `iorq_n_i`=0, `rd_n_i`=1, `ien_in_i`=1 with a request pending. From that edge on, `data_oe_o` is 1 and `data_o` equals the `vector_i` sampled at that edge. The in-service flag is set and the pending flag is cleared. The drive ends after the first edge that samples `m1_n_i` or `iorq_n_i` high.
- R5: An acknowledge sampled with `ien_in_i`=0, or with no request pending, drives nothing and leaves the pending flag unchanged.
- R6: While the in-service flag is set, `ien_out_o` is 0 and `int_n_o` is 1.
- R7: An opcode fetch is `m1_n_i`=0, `rd_n_i`=0, `iorq_n_i`=1. The opcode byte is taken from `data_i` at the first edge of each fetch. A fetch of 0xED followed by a fetch of 0x4D, with `ien_in_i`=1, clears the in-service flag at the edge that takes 0x4D.
- R8: A fetch other than 0x4D after 0xED cancels the sequence, so a later 0x4D does not clear the flag. A repeated 0xED restarts it, so 0xED, 0xED, 0x4D clears the flag.
- R9: A complete return sequence fetched while `ien_in_i` is 0 leaves the in-service flag set.
- R10: An `irq_pulse_i` at the same edge as an accepted acknowledge leaves a new request pending.
- R11: A fetch cycle is never taken as an acknowledge. It never enables the data drive and never consumes the pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_pulse_i | input | 1 | One-cycle interrupt request from the peripheral |
| m1_n_i | input | 1 | Machine-cycle-one strobe, active low |
| iorq_n_i | input | 1 | I/O request strobe, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| ien_in_i | input | 1 | Chain enable from the higher-priority neighbour |
| ien_out_o | output | 1 | Chain enable to the lower-priority neighbour |
| int_n_o | output | 1 | Interrupt request, active low (open-drain value) |
| data_i | input | 8 | Data bus as seen by the node (opcode snooping) |
| vector_i | input | 8 | Vector to present on acknowledge |
| data_o | output | 8 | Vector driven onto the data bus |
| data_oe_o | output | 1 | Data bus output enable |

## Verification
The flags and the vector drive change at the edge that samples their cause: a pulse, an acknowledge or the 0x4D fetch. The result is therefore due one edge after the stimulus is set up. `ien_out_o` and `int_n_o` also follow `ien_in_i` in the same cycle, with no edge in between. The bench drives inputs on the falling edge and compares all outputs with its behavioural model shortly after, so each comparison sees the state after the last rising edge combined with the present enable input. Directed scenarios check each corner case at the cycle where it is due. A randomised strobe phase then compares the outputs on every cycle.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int unsigned BUS_W = 8;
  localparam logic [BUS_W-1:0] RET_PREFIX = 8'hED;
  localparam logic [BUS_W-1:0] RET_SUFFIX = 8'h4D;

  typedef struct packed {
    logic ack_io;      // acknowledge with I/O request asserted
    logic fetch_first; // first sampled edge of an opcode fetch
  } bus_evt_t;
endpackage

// File: rtl/ichn_strobe_decode.sv
module ichn_strobe_decode
  import irq_chain_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     m1_n_i,
  input  logic     iorq_n_i,
  input  logic     rd_n_i,
  output bus_evt_t evt_o
);
  logic fetch_now;
  logic fetch_seen_q;
  logic fetch_seen_d;

  // Fetch: M1 and RD active, no I/O request. Acknowledge: M1 active, RD idle.
  always_comb begin
    fetch_now         = !m1_n_i && !rd_n_i && iorq_n_i;
    fetch_seen_d      = fetch_now;
    evt_o.fetch_first = fetch_now && !fetch_seen_q;
    evt_o.ack_io      = !m1_n_i && rd_n_i && !iorq_n_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fetch_seen_q <= 1'b0;
    else        fetch_seen_q <= fetch_seen_d;
  end
endmodule

// File: rtl/ichn_ret_snoop.sv
module ichn_ret_snoop
  import irq_chain_pkg::*;
#(
  parameter int unsigned W = BUS_W,
  parameter logic [W-1:0] PREFIX = RET_PREFIX,
  parameter logic [W-1:0] SUFFIX = RET_SUFFIX
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fetch_first_i,
  input  logic [W-1:0] data_i,
  output logic         ret_hit_o
);
  logic armed_q;
  logic armed_d;

  always_comb begin
    armed_d   = armed_q;
    ret_hit_o = 1'b0;
    if (fetch_first_i) begin
      ret_hit_o = armed_q && (data_i == SUFFIX);
      armed_d   = (data_i == PREFIX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/ichn_flags.sv
module ichn_flags
  import irq_chain_pkg::*;
#(
  parameter int unsigned W = BUS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         irq_pulse_i,
  input  logic         ack_io_i,
  input  logic         ret_hit_i,
  input  logic         chain_en_i,
  input  logic [W-1:0] vector_i,
  output logic         pend_o,
  output logic         serv_o,
  output logic         drive_o,
  output logic [W-1:0] vec_o
);
  logic         pend_q, pend_d;
  logic         serv_q, serv_d;
  logic         drive_q, drive_d;
  logic [W-1:0] vec_q, vec_d;
  logic         take;
  logic         vec_en;

  always_comb begin
    take    = ack_io_i && !drive_q && chain_en_i && pend_q;
    vec_en  = take;
    vec_d   = vector_i;
    pend_d  = irq_pulse_i || (pend_q && !take);
    serv_d  = take || (serv_q && !(ret_hit_i && chain_en_i));
    drive_d = ack_io_i && (drive_q || take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      serv_q  <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      serv_q  <= serv_d;
      drive_q <= drive_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  assign pend_o  = pend_q;
  assign serv_o  = serv_q;
  assign drive_o = drive_q;
  assign vec_o   = vec_q;

  // R7: a completed return seen with the chain enabled ends service
  a_r7_return_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_hit_i && chain_en_i && !ack_io_i) |=> !serv_q);
  // R10: a source pulse always leaves a request pending
  a_r10_pulse_pends: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_i |=> pend_q);
endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node
  import irq_chain_pkg::*;
#(
  parameter int unsigned W = BUS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         irq_pulse_i,
  input  logic         m1_n_i,
  input  logic         iorq_n_i,
  input  logic         rd_n_i,
  input  logic         ien_in_i,
  output logic         ien_out_o,
  output logic         int_n_o,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] vector_i,
  output logic [W-1:0] data_o,
  output logic         data_oe_o
);
  bus_evt_t     evt;
  logic         ret_hit;
  logic         pend, serv, drive;
  logic [W-1:0] vec;

  ichn_strobe_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .m1_n_i   (m1_n_i),
    .iorq_n_i (iorq_n_i),
    .rd_n_i   (rd_n_i),
    .evt_o    (evt)
  );

  ichn_ret_snoop #(.W(W)) u_snoop (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_first_i (evt.fetch_first),
    .data_i        (data_i),
    .ret_hit_o     (ret_hit)
  );

  ichn_flags #(.W(W)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_pulse_i (irq_pulse_i),
    .ack_io_i    (evt.ack_io),
    .ret_hit_i   (ret_hit),
    .chain_en_i  (ien_in_i),
    .vector_i    (vector_i),
    .pend_o      (pend),
    .serv_o      (serv),
    .drive_o     (drive),
    .vec_o       (vec)
  );

  // Pending or in-service both block the lower chain.
  assign ien_out_o = ien_in_i && !pend && !serv;
  assign int_n_o   = !(pend && !serv && ien_in_i);
  assign data_oe_o = drive;
  assign data_o    = drive ? vec : '0;

  // R4: the drive only begins on an acknowledge with I/O request
  a_r4_drive_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) |-> ($past(!m1_n_i) && $past(!iorq_n_i) && $past(rd_n_i)));
  // R4: the acknowledged request moves from pending to in service
  a_r4_take_moves_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) |-> (serv && $past(pend)));
  // R5: a node without chain enable never starts a drive
  a_r5_no_drive_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) |-> $past(ien_in_i));
  // R4: the vector holds steady for the whole drive
  a_r4_vector_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe_o && $past(data_oe_o)) |-> $stable(data_o));
  // R11: a fetch cycle never turns on the drive
  a_r11_fetch_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!m1_n_i && !rd_n_i) |=> !$rose(data_oe_o));
endmodule

// File: tb/irq_chain_node_tb_top.sv
module irq_chain_node_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       irq_pulse, m1_n, iorq_n, rd_n, ien_in;
  logic [7:0] data_in, vector;
  logic       ien_out, int_n, data_oe;
  logic [7:0] data_out;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  bit       m_pend, m_serv, m_drive, m_prev_fetch, m_armed;
  bit [7:0] m_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_chain_node dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pulse_i(irq_pulse),
    .m1_n_i(m1_n), .iorq_n_i(iorq_n), .rd_n_i(rd_n),
    .ien_in_i(ien_in), .ien_out_o(ien_out), .int_n_o(int_n),
    .data_i(data_in), .vector_i(vector), .data_o(data_out), .data_oe_o(data_oe)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_serv = 0; m_drive = 0; m_prev_fetch = 0; m_armed = 0; m_vec = 0;
    end else begin
      bit fetch, ack, first, take, ret;
      fetch = !m1_n && !rd_n && iorq_n;
      ack   = !m1_n && rd_n && !iorq_n;
      first = fetch && !m_prev_fetch;
      take  = ack && !m_drive && ien_in && m_pend;
      ret   = first && m_armed && data_in == 8'h4D;
      if (first) m_armed = (data_in == 8'hED);
      m_prev_fetch = fetch;
      if (take) begin m_vec = vector; m_serv = 1; m_pend = 0; end
      else if (ret && ien_in) m_serv = 0;
      if (irq_pulse) m_pend = 1;
      m_drive = ack && (m_drive || take);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    bit e_ieo, e_int;
    e_ieo = ien_in && !m_pend && !m_serv;
    e_int = !(m_pend && !m_serv && ien_in);
    chk(ien_out == e_ieo, "R2 R6 ien_out_o", ien_out, e_ieo);
    chk(int_n == e_int, "R3 int_n_o", int_n, e_int);
    chk(data_oe == m_drive, "R4 data_oe_o", data_oe, m_drive);
    chk(data_out == (m_drive ? m_vec : 8'h00), "R4 data_o", data_out, m_drive ? m_vec : 8'h00);
  endtask

  // one clock: set inputs at the falling edge, compare, then let the rising edge act
  task automatic cyc(input bit p, input bit m1, input bit io, input bit rd, input bit en, input bit [7:0] d);
    @(negedge clk);
    irq_pulse = p; m1_n = m1; iorq_n = io; rd_n = rd; ien_in = en; data_in = d;
    #1 compare_model();
  endtask

  task automatic idle(input bit en); cyc(0, 1, 1, 1, en, 8'h00); endtask
  task automatic fetch(input bit en, input bit [7:0] b);
    cyc(0, 0, 1, 0, en, b); cyc(0, 0, 1, 0, en, b); idle(en);
  endtask
  task automatic ack(input bit en, input bit p);
    cyc(p, 0, 0, 1, en, 8'h00); cyc(0, 0, 0, 1, en, 8'h00); idle(en);
  endtask
  task automatic pulse(input bit en); cyc(1, 1, 1, 1, en, 8'h00); endtask
  task automatic settle(input bit en); @(negedge clk); ien_in = en; irq_pulse = 0; #1; endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    irq_pulse = 0; m1_n = 1; iorq_n = 1; rd_n = 1; ien_in = 1; data_in = 0; vector = 8'hA5;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(int_n == 1, "R1 int_n_o after reset", int_n, 1);
    chk(data_oe == 0, "R1 data_oe_o after reset", data_oe, 0);
    chk(ien_out == 1, "R1 ien_out_o after reset", ien_out, 1);

    // R2 and R3: a request blocks the chain
    pulse(1); idle(1);
    chk(int_n == 0, "R3 request asserted", int_n, 0);
    chk(ien_out == 0, "R2 chain blocked with enable high", ien_out, 0);
    settle(0);
    chk(ien_out == 0, "R2 chain blocked with enable low", ien_out, 0);
    chk(int_n == 1, "R3 no request without enable", int_n, 1);

    // R5 blocked acknowledge
    ack(0, 0); settle(1);
    chk(data_oe == 0 && int_n == 0, "R5 blocked ack leaves request", int_n, 0);

    // R4 acknowledge
    vector = 8'h3C;
    cyc(0, 0, 0, 1, 1, 8'h00);
    cyc(0, 0, 0, 1, 1, 8'h00);
    chk(data_oe == 1, "R4 drive on", data_oe, 1);
    chk(data_out == 8'h3C, "R4 vector value", data_out, 8'h3C);
    vector = 8'h99;
    cyc(0, 0, 0, 1, 1, 8'h00);
    chk(data_out == 8'h3C, "R4 vector held", data_out, 8'h3C);
    idle(1); idle(1);
    chk(data_oe == 0, "R4 drive released", data_oe, 0);
    chk(ien_out == 0 && int_n == 1, "R6 in service blocks", ien_out, 0);

    // R8 broken sequence, then R7 clean return
    fetch(1, 8'hED); fetch(1, 8'h00); fetch(1, 8'h4D); settle(1);
    chk(ien_out == 0, "R8 broken sequence ignored", ien_out, 0);
    fetch(1, 8'hED); fetch(1, 8'h4D); settle(1);
    chk(ien_out == 1, "R7 return clears service", ien_out, 1);

    // R9 return without enable; then R8 restart with repeated prefix
    pulse(1); ack(1, 0);
    fetch(0, 8'hED); fetch(0, 8'h4D); settle(1);
    chk(ien_out == 0, "R9 return ignored without enable", ien_out, 0);
    fetch(1, 8'hED); fetch(1, 8'hED); fetch(1, 8'h4D); settle(1);
    chk(ien_out == 1, "R8 repeated prefix restarts", ien_out, 1);

    // R10 pulse at acknowledge edge
    pulse(1); ack(1, 1); settle(1);
    chk(int_n == 1 && ien_out == 0, "R10 in service with new pending", ien_out, 0);
    fetch(1, 8'hED); fetch(1, 8'h4D); settle(1);
    chk(int_n == 0, "R10 new request surfaces after return", int_n, 0);

    // R11 fetch is not an acknowledge
    cyc(0, 0, 1, 0, 1, 8'h00); cyc(0, 0, 1, 0, 1, 8'h00); settle(1);
    chk(data_oe == 0, "R11 fetch drives nothing", data_oe, 0);
    chk(int_n == 0, "R11 request kept through fetch", int_n, 0);

    // random phase compared to the model every cycle
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      vector = 8'($urandom);
      case (k)
        0: cyc(1, 1, 1, 1, 1'($urandom), 8'h00);
        1, 2: cyc(0, 0, 0, 1, 1'($urandom_range(0, 3) != 0), 8'h00);
        3: cyc(0, 0, 1, 0, 1, 8'hED);
        4: cyc(0, 0, 1, 0, 1'($urandom_range(0, 3) != 0), 8'h4D);
        5: cyc(0, 0, 1, 0, 1, 8'($urandom));
        default: cyc(1'($urandom_range(0, 7) == 0), 1, 1, 1, 1'($urandom_range(0, 3) != 0), 8'h00);
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule